// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Divider

This block derives a serial bit clock from one of two tick sources and a programmable divide value. The internal source produces a tick on every second system clock. The external source produces one tick for each rising edge of an asynchronous clock input, after that input has passed through a synchronizer. One output period spans DIV + 1 ticks. The high phase comes first. When DIV is even, the high phase takes the extra tick. When DIV is odd, the two phases are equal.

Alongside the clock level, the block emits one-cycle rise and fall strobes that a serial shift engine can use as enables. The divide value and the source choice are captured only at the tick that opens a period, so software may rewrite them at any time without producing a runt phase. A disable input parks the clock low and rewinds the period. The setting used for slave operation is the internal source with DIV = 1. It gives a bit clock at one quarter of the system clock.

Top module: `sclk_div`

## Requirements
- R1: While rst_ni is low, sclk_o, rise_o and fall_o are all 0.
- R2: With ext_sel_i = 0 (internal source), one tick occurs every second system clock, so one output period lasts 2*(DIV+1) system clocks.
- R3: With ext_sel_i = 1 (external source), one tick occurs for each rising edge of ext_clk_i, so the phase lengths scale with the external period.
- R4: For even nonzero DIV, the high phase lasts DIV/2 + 1 ticks and the low phase lasts DIV/2 ticks.
- R5: For odd DIV, the high phase and the low phase each last (DIV+1)/2 ticks.
- R6: With DIV = 0, every tick opens a new period. sclk_o is high for exactly one system clock and then low until the next tick. With the internal source this gives a square wave at half the system clock.
- R7: rise_o is 1 only in the first cycle in which sclk_o is 1. fall_o is 1 only in the first cycle in which sclk_o is 0. The two strobes are never 1 together.
- R8: div_i and ext_sel_i are sampled only at the tick that opens a period. A change made during a period does not alter the phase lengths or the source of that period.
- R9: While en_i is 0, sclk_o is 0 from the following cycle on. The next period after re-enabling starts with a full high phase.
- R10: The internal source with DIV = 1 yields a period of 4 system clocks: 2 cycles high and 2 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable; 0 parks the clock low |
| ext_sel_i | input | 1 | Tick source: 0 internal half-rate, 1 external clock |
| ext_clk_i | input | 1 | External clock, asynchronous to clk_i |
| div_i | input | DIV_W | Divide value DIV |
| sclk_o | output | 1 | Divided bit clock level |
| rise_o | output | 1 | One-cycle strobe on the first high cycle |
| fall_o | output | 1 | One-cycle strobe on the first low cycle |

## Verification
The bench builds the divider with DIV_W = 4 and a two-stage synchronizer. This makes every divide value from 0 up to the maximum of 15 reachable in short runs, covering both parities and the DIV = 0 special case, for both the internal source and external clocks of several periods. The narrow width also keeps the longest external period short enough that mid-period rewrites of the divide value and the source, together with disable and re-enable, can each be observed over several complete periods.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/sclk_tick_src.sv
module sclk_tick_src #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ext_clk_i,
  output logic int_tick_o,
  output logic ext_tick_o
);
  logic          half_q;
  logic [SYNC:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      sync_q <= '0;
    end else begin
      half_q <= en_i ? ~half_q : 1'b0;
      sync_q <= {sync_q[SYNC-1:0], ext_clk_i};
    end
  end

  assign int_tick_o = half_q;
  // edge of last synchronizer stage
  assign ext_tick_o = sync_q[SYNC-1] & ~sync_q[SYNC];
endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr
  import sclk_div_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  src_e             sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0]    pos_q, pos_n;
  logic [DIV_W-1:0] cur_div_q;
  src_e             cur_sel_q;
  logic             sclk_q, sclk_n, rise_q, fall_q;

  logic             at_start, tick;
  logic [DIV_W-1:0] eff_div;
  src_e             eff_sel;
  logic [CW-1:0]    div_x, hi_len;

  // period start uses live settings, otherwise the latched ones
  assign at_start = (pos_q == '0);
  assign eff_div  = at_start ? div_i : cur_div_q;
  assign eff_sel  = at_start ? sel_i : cur_sel_q;
  assign tick     = (eff_sel == SRC_EXT) ? ext_tick_i : int_tick_i;
  assign div_x    = {1'b0, eff_div};
  assign hi_len   = eff_div[0] ? ((div_x + CW'(1)) >> 1) : ((div_x >> 1) + CW'(1));

  always_comb begin
    pos_n  = pos_q;
    sclk_n = sclk_q;
    if (!en_i) begin
      pos_n  = '0;
      sclk_n = 1'b0;
    end else if (tick) begin
      sclk_n = (pos_q < hi_len);
      pos_n  = (pos_q == div_x) ? '0 : pos_q + CW'(1);
    end else if (cur_div_q == '0) begin
      sclk_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      cur_div_q <= '0;
      cur_sel_q <= SRC_INT;
      sclk_q    <= 1'b0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
    end else begin
      if (en_i && tick && at_start) begin
        cur_div_q <= div_i;
        cur_sel_q <= sel_i;
      end
      pos_q  <= pos_n;
      sclk_q <= sclk_n;
      rise_q <= sclk_n & ~sclk_q;
      fall_q <= ~sclk_n & sclk_q;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/sclk_div.sv
module sclk_div
  import sclk_div_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic int_tick, ext_tick;

  sclk_tick_src #(.SYNC(SYNC)) i_tick_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ext_clk_i  (ext_clk_i),
    .int_tick_o (int_tick),
    .ext_tick_o (ext_tick)
  );

  sclk_phase_ctr #(.DIV_W(DIV_W)) i_phase_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sel_i      (src_e'(ext_sel_i)),
    .div_i      (div_i),
    .int_tick_i (int_tick),
    .ext_tick_i (ext_tick),
    .sclk_o     (sclk_o),
    .rise_o     (rise_o),
    .fall_o     (fall_o)
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sclk_o,
  input logic rise_o,
  input logic fall_o
);
  a_r7_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> sclk_o);
  a_r7_fall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !sclk_o);
  a_r7_rise_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> rise_o);
  a_r7_fall_strobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> fall_o);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  a_r9_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_o);
endmodule

bind sclk_div sclk_div_chk i_sclk_div_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .sclk_o (sclk_o),
  .rise_o (rise_o),
  .fall_o (fall_o)
);

// File: tb/test_sclk_div.sv
module test_sclk_div;
  localparam int DIV_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             ext_sel_i = 1'b0;
  logic             ext_clk_i = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic             sclk_o, rise_o, fall_o;

  int n_chk = 0, n_fail = 0, cyc = 0, ext_half = 3, strobe_err = 0, n_rise = 0;
  logic prev_s = 1'b0;

  sclk_div #(.DIV_W(DIV_W), .SYNC(2)) i_sclk_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ext_sel_i(ext_sel_i),
    .ext_clk_i(ext_clk_i), .div_i(div_i),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  always #5 clk_i = ~clk_i;

  always begin
    repeat (ext_half) @(negedge clk_i);
    ext_clk_i = ~ext_clk_i;
  end

  // R7 strobe monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rise_o !== (sclk_o & ~prev_s)) strobe_err++;
      if (fall_o !== (~sclk_o & prev_s)) strobe_err++;
      if (rise_o) n_rise++;
    end
    prev_s = sclk_o;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!rise_o && k < 4000);
  endtask

  task automatic run_len(output int n);
    logic lvl = sclk_o;
    n = 0;
    while (sclk_o == lvl && n < 4000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  function automatic int tick_p(logic ext, int half);
    return ext ? 2 * half : 2;
  endfunction

  function automatic int exp_hi(int d, int p);
    if (d == 0) return 1;
    return p * ((d % 2) ? (d + 1) / 2 : d / 2 + 1);
  endfunction

  function automatic int exp_lo(int d, int p);
    if (d == 0) return p - 1;
    return p * ((d % 2) ? (d + 1) / 2 : d / 2);
  endfunction

  task automatic measure(int d, logic ext, int half, string req);
    int h, l, p;
    @(negedge clk_i);
    div_i = DIV_W'(d);
    ext_sel_i = ext;
    ext_half = half;
    p = tick_p(ext, half);
    wait_rise();
    wait_rise();
    wait_rise();
    run_len(h);
    run_len(l);
    check($sformatf("%s high d=%0d ext=%0d", req, d, ext), h, exp_hi(d, p));
    check($sformatf("%s low d=%0d ext=%0d", req, d, ext), l, exp_lo(d, p));
  endtask

  initial begin
    int h, l, d, hf;
    logic ex;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R1 sclk in reset", sclk_o, 0);
    check("R1 rise in reset", rise_o, 0);
    check("R1 fall in reset", fall_o, 0);
    rst_ni = 1'b1;
    en_i = 1'b1;

    measure(1, 1'b0, 3, "R10");
    measure(6, 1'b0, 3, "R2/R4");
    measure(3, 1'b0, 3, "R2/R5");
    measure(3, 1'b1, 3, "R3/R5");
    measure(4, 1'b1, 2, "R3/R4");
    measure(0, 1'b0, 3, "R6");
    measure(0, 1'b1, 2, "R6/R3");
    measure(15, 1'b0, 3, "R5 max");
    measure(14, 1'b1, 2, "R4 max");

    // R8: divide change during the high phase
    measure(4, 1'b0, 3, "R8 setup");
    wait_rise();
    div_i = DIV_W'(1);
    run_len(h);
    run_len(l);
    check("R8 old high kept", h, 6);
    check("R8 old low kept", l, 4);
    wait_rise();
    run_len(h);
    run_len(l);
    check("R8 new high", h, 2);
    check("R8 new low", l, 2);

    // R8: source change during the high phase
    measure(2, 1'b0, 4, "R8 src setup");
    wait_rise();
    ext_sel_i = 1'b1;
    run_len(h);
    check("R8 source kept for high", h, 4);
    wait_rise();
    wait_rise();
    run_len(h);
    run_len(l);
    check("R8 new source high", h, 16);
    check("R8 new source low", l, 8);

    // R9: disable parks low
    @(negedge clk_i);
    ext_sel_i = 1'b0;
    div_i = DIV_W'(2);
    wait_rise();
    en_i = 1'b0;
    @(negedge clk_i);
    h = 0;
    for (int i = 0; i < 30; i++) begin
      if (sclk_o) h++;
      @(negedge clk_i);
    end
    check("R9 low while disabled", h, 0);
    en_i = 1'b1;
    wait_rise();
    run_len(h);
    run_len(l);
    check("R9 full high after enable", h, 4);
    check("R9 low after enable", l, 2);

    for (int it = 0; it < 24; it++) begin
      d  = $urandom_range(0, (1 << DIV_W) - 1);
      ex = 1'($urandom_range(0, 1));
      hf = $urandom_range(2, 4);
      measure(d, ex, hf, (d == 0) ? "R6 rnd" : ((d % 2) ? "R5 rnd" : "R4 rnd"));
    end

    check("R7 strobe mismatches", strobe_err, 0);
    check("R7 rises seen", (n_rise > 0) ? 1 : 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule